// File: doc/BRIEF.md
# Four-Lane Two-Stage Decision Feedback Filter

This block is the decision loop of a two-level (binary) decision feedback equalizer that must keep pace with four received samples per clock. Each clock it takes four consecutive equalized-forward samples. It subtracts the trailing inter-symbol interference of a six-tap feedback filter from each one and slices the result into a binary decision. The four decisions come out per clock.

The feedback taps are split into two groups. The older group holds taps 4 to 6. Those three decisions always come from earlier clocks, so each lane picks one of eight precomputed weight sums for them with a plain table lookup. The newer group holds taps 1 to 3, and its decisions may come from lanes of the same clock. Each lane therefore merges its sample with the older-group sum and each of the eight newer-group sums, slices all eight results, and lets the chain of decisions from earlier lanes pick the right one. The only path through the loop is then a chain of 8-to-1 selections from lane 0 to lane 3. The weight tables are shared by all lanes and are registered together with the samples, so the merge adders are fed straight from registers.

The stream of decisions is the same as the one a one-sample-per-step recursion produces on the same sample sequence.

Top module: `dfe4_top`

## Requirements
- R1: After reset `outValid` and `decOut` are 0, and the decision history is taken as six -1 symbols.
- R2: Lane j sample is `sampleBus[10j+9:10j]` (signed two's complement), and lane 0 is the oldest sample of the block. Decision bit j of `decOut` belongs to lane j.
- R3: The decision for sample n is 1 when x[n] + sum over k=1..6 of w_k·a[n-k] is at least 0, and 0 otherwise. Here a = +1 for decision bit 1 and -1 for bit 0. Weight w_k is the signed byte `weightBus[8k-1:8k-8]`.
- R4: Over any run of blocks, the decisions equal those of the serial recursion of R3 applied to the samples in lane order.
- R5: A block presented with `inValid` high at clock edge E has its decisions on `decOut` with `outValid` high after edge E+1, for exactly one cycle per block.
- R6: Cycles with `inValid` low leave the decision history and `decOut` unchanged, and produce no `outValid`.
- R7: Lane j uses the decisions of lanes 0..j-1 of the same block for its newest taps.
- R8: Taps that reach past the current block use decisions of earlier blocks, back to two blocks before (lane 0, tap 6 uses lane 2 of the block two earlier).
- R9: A filter sum of exactly zero gives decision 1.
- R10: The weights used for a block are those on `weightBus` at the same edge that captures its samples, so the weights may change on every block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A block of four samples is present |
| sampleBus | input | 40 | Four signed 10-bit samples, lane 0 in the low bits |
| weightBus | input | 48 | Six signed 8-bit feedback weights, tap 1 in the low byte |
| outValid | output | 1 | `decOut` holds a new block of decisions |
| decOut | output | 4 | Decisions, bit j for lane j, 1 means +1 |

## Verification
A block driven at one falling edge is captured at the next rising edge. Its decisions appear after the following rising edge, so they are due at the second falling edge after the drive. The scoreboard stores each block's expected decisions together with that due cycle. The monitor compares the value and checks that the arrival cycle matches, so both content and latency are checked for every block. Idle gaps and weight changes on every block are mixed in, so history holding across gaps and per-block weight capture are covered by the same comparisons.

// File: rtl/dfe4_pkg.sv
package dfe4_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic capture;  // register samples and weight tables this edge
    logic advance;  // commit decisions and shift history this edge
  } dfeStrobe_t;

endpackage

// File: rtl/dfe4_tables.sv
// Precomputes the weight-sum tables for the two tap groups and registers them
// together with the samples (the register sits ahead of the merge adders).
module dfe4_tables #(
  parameter int TAPS     = 6,
  parameter int SPLIT    = 3,
  parameter int WEIGHT_W = 8,
  parameter int ACC_W    = 12
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   load,
  input  logic [TAPS*WEIGHT_W-1:0]               weightBus,
  output logic [(1<<(TAPS-SPLIT))-1:0][ACC_W-1:0] t1,
  output logic [(1<<SPLIT)-1:0][ACC_W-1:0]        t2
);
  localparam int S1_N = TAPS - SPLIT;
  localparam int TBL1 = 1 << S1_N;
  localparam int TBL2 = 1 << SPLIT;

  // Older group: taps SPLIT+1..TAPS, index bit i = decision of tap SPLIT+1+i.
  for (genvar c = 0; c < TBL1; c++) begin : olderGen
    logic signed [ACC_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < S1_N; i++) begin
        logic signed [WEIGHT_W-1:0] wv;
        wv = $signed(weightBus[(SPLIT+i)*WEIGHT_W +: WEIGHT_W]);
        if (((c >> i) & 1) != 0) acc = acc + ACC_W'(wv);
        else                     acc = acc - ACC_W'(wv);
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     t1[c] <= '0;
      else if (load) t1[c] <= acc;
    end
  end

  // Newer group: taps 1..SPLIT, index bit i = decision of tap i+1.
  for (genvar c = 0; c < TBL2; c++) begin : newerGen
    logic signed [ACC_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < SPLIT; i++) begin
        logic signed [WEIGHT_W-1:0] wv;
        wv = $signed(weightBus[i*WEIGHT_W +: WEIGHT_W]);
        if (((c >> i) & 1) != 0) acc = acc + ACC_W'(wv);
        else                     acc = acc - ACC_W'(wv);
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     t2[c] <= '0;
      else if (load) t2[c] <= acc;
    end
  end
endmodule

// File: rtl/dfe4_lane.sv
// One lane: older-group lookup, eight merge adders with slicers, and the
// 8-to-1 selection driven by the newer decisions.
module dfe4_lane #(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W    = 12,
  parameter int S1_N     = 3,
  parameter int S2_N     = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [SAMPLE_W-1:0]               sample,
  input  logic [(1<<S1_N)-1:0][ACC_W-1:0]   t1,
  input  logic [(1<<S2_N)-1:0][ACC_W-1:0]   t2,
  input  logic [S1_N-1:0]                   s1Idx,
  input  logic [S2_N-1:0]                   s2Idx,
  output logic                              dec
);
  localparam int TBL2 = 1 << S2_N;

  logic signed [ACC_W-1:0] sampleExt;
  logic signed [ACC_W-1:0] olderSum;
  logic [TBL2-1:0]         candBit;

  assign sampleExt = ACC_W'($signed(sample));
  assign olderSum  = $signed(t1[s1Idx]);

  for (genvar c = 0; c < TBL2; c++) begin : candGen
    logic signed [ACC_W-1:0] merged;
    assign merged     = sampleExt + olderSum + $signed(t2[c]);
    assign candBit[c] = ~merged[ACC_W-1];   // slicer: non-negative -> 1
  end

  assign dec = candBit[s2Idx];

  // The selected candidate must equal a direct slice of the full sum.
  logic signed [ACC_W-1:0] directSum;
  assign directSum = sampleExt + olderSum + $signed(t2[s2Idx]);

  assert_select_matches_sum_R3: assert property (@(posedge clk) disable iff (!rstN)
    dec == (directSum >= 0));
  assert_zero_slices_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    (directSum == 0) |-> dec);
endmodule

// File: rtl/dfe4_ctrl.sv
module dfe4_ctrl
  import dfe4_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output dfeStrobe_t strobe,
  output logic       outValid
);
  logic advanceReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      advanceReg <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      advanceReg <= inValid;
      outValid   <= advanceReg;
    end
  end

  assign strobe.capture = inValid;
  assign strobe.advance = advanceReg;

  assert_two_edge_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid, 2));
  assert_no_output_when_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> !outValid);
endmodule

// File: rtl/dfe4_datapath.sv
module dfe4_datapath
  import dfe4_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int TAPS     = 6,
  parameter int SPLIT    = 3,
  parameter int SAMPLE_W = 10,
  parameter int WEIGHT_W = 8,
  parameter int ACC_W    = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dfeStrobe_t                  strobe,
  input  logic [LANES*SAMPLE_W-1:0]   sampleBus,
  input  logic [TAPS*WEIGHT_W-1:0]    weightBus,
  output logic [LANES-1:0]            decOut
);
  localparam int S1_N = TAPS - SPLIT;
  localparam int TBL1 = 1 << S1_N;
  localparam int TBL2 = 1 << SPLIT;

  logic [TBL1-1:0][ACC_W-1:0]    t1;
  logic [TBL2-1:0][ACC_W-1:0]    t2;
  logic [LANES*SAMPLE_W-1:0]     sampleReg;
  logic [TAPS-1:0]               histReg;   // bit 0 = most recent decision
  logic [TAPS-1:0]               histNext;
  logic [LANES-1:0]              decVec;

  dfe4_tables #(
    .TAPS(TAPS), .SPLIT(SPLIT), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)
  ) tables_i (
    .clk(clk), .rstN(rstN), .load(strobe.capture),
    .weightBus(weightBus), .t1(t1), .t2(t2)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sampleReg <= '0;
    else if (strobe.capture)  sampleReg <= sampleBus;
  end

  // Lane j, tap k: same-block lane j-k if it exists, else history.
  for (genvar j = 0; j < LANES; j++) begin : laneGen
    logic [TAPS-1:0] tapBit;
    logic            laneDec;
    for (genvar k = 1; k <= TAPS; k++) begin : tapGen
      if (j - k >= 0) begin : fromLane
        assign tapBit[k-1] = laneGen[j-k].laneDec;
      end else begin : fromHist
        assign tapBit[k-1] = histReg[k-j-1];
      end
    end

    dfe4_lane #(
      .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .S1_N(S1_N), .S2_N(SPLIT)
    ) lane_i (
      .clk(clk), .rstN(rstN),
      .sample(sampleReg[j*SAMPLE_W +: SAMPLE_W]),
      .t1(t1), .t2(t2),
      .s1Idx(tapBit[TAPS-1:SPLIT]),
      .s2Idx(tapBit[SPLIT-1:0]),
      .dec(laneDec)
    );
    assign decVec[j] = laneDec;
  end

  for (genvar i = 0; i < TAPS; i++) begin : histGen
    if (i < LANES) begin : fresh
      assign histNext[i] = decVec[LANES-1-i];
    end else begin : carried
      assign histNext[i] = histReg[i-LANES];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histReg <= '0;
      decOut  <= '0;
    end else if (strobe.advance) begin
      histReg <= histNext;
      decOut  <= decVec;
    end
  end

  assert_hist_holds_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> ($stable(histReg) && $stable(decOut)));
  assert_newest_is_last_lane_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> histReg[0] == decOut[LANES-1]);
  if (TAPS > LANES) begin : shiftChk
    assert_hist_spans_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobe.advance |=> histReg[TAPS-1:LANES] == $past(histReg[TAPS-1-LANES:0]));
  end
endmodule

// File: rtl/dfe4_top.sv
module dfe4_top
  import dfe4_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int TAPS     = 6,
  parameter int SPLIT    = 3,
  parameter int SAMPLE_W = 10,
  parameter int WEIGHT_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [LANES*SAMPLE_W-1:0]  sampleBus,
  input  logic [TAPS*WEIGHT_W-1:0]   weightBus,
  output logic                       outValid,
  output logic [LANES-1:0]           decOut
);
  // Headroom: sample plus the sum of all tap magnitudes.
  localparam int ACC_W = ((SAMPLE_W > WEIGHT_W + 3) ? SAMPLE_W : WEIGHT_W + 3) + 2;

  dfeStrobe_t strobe;

  dfe4_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  dfe4_datapath #(
    .LANES(LANES), .TAPS(TAPS), .SPLIT(SPLIT),
    .SAMPLE_W(SAMPLE_W), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleBus(sampleBus), .weightBus(weightBus), .decOut(decOut)
  );
endmodule

// File: tb/dfe4_top_tb_top.sv
module dfe4_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [39:0] sampleBus = '0;
  logic [47:0] weightBus = '0;
  logic        outValid;
  logic [3:0]  decOut;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  bit done = 1'b0;

  logic [3:0] expQ[$];
  int         dueQ[$];
  string      tagQ[$];
  bit         histM[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycle++;

  dfe4_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sampleBus(sampleBus),
    .weightBus(weightBus), .outValid(outValid), .decOut(decOut)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Serial reference recursion (R3): one sample at a time, lane 0 first.
  function automatic logic [3:0] model(logic [39:0] s, logic [47:0] w);
    logic [3:0] r;
    for (int j = 0; j < 4; j++) begin
      int y;
      y = int'($signed(s[10*j +: 10]));
      for (int k = 1; k <= 6; k++) begin
        int wk;
        wk = int'($signed(w[8*(k-1) +: 8]));
        y += histM[histM.size()-k] ? wk : -wk;
      end
      r[j] = (y >= 0);
      histM.push_back(r[j]);
      if (histM.size() > 6) void'(histM.pop_front());
    end
    return r;
  endfunction

  task automatic sendBlock(logic [39:0] s, logic [47:0] w, string tag);
    @(negedge clk);
    inValid   = 1'b1;
    sampleBus = s;
    weightBus = w;
    expQ.push_back(model(s, w));
    dueQ.push_back(cycle + 2);
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid   = 1'b0;
      sampleBus = 40'($urandom);
    end
  endtask

  function automatic logic [39:0] pack4(int a, int b, int c, int d);
    return {10'(d), 10'(c), 10'(b), 10'(a)};
  endfunction

  function automatic logic [47:0] packW(int w1, int w2, int w3, int w4, int w5, int w6);
    return {8'(w6), 8'(w5), 8'(w4), 8'(w3), 8'(w2), 8'(w1)};
  endfunction

  // Scoreboard monitor: value and arrival cycle of every block.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 output with no block pending", int'(decOut), 0);
      end else begin
        logic [3:0] e;
        int due;
        string t;
        e = expQ.pop_front();
        due = dueQ.pop_front();
        t = tagQ.pop_front();
        check(decOut == e, t, int'(decOut), int'(e));
        check(cycle == due, {"R5 latency ", t}, cycle, due);
      end
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) histM.push_back(1'b0);
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(decOut == 4'b0, "R1 decOut in reset", int'(decOut), 0);
    rstN = 1'b1;
    idle(2);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);

    // R1: reset history is all -1, seen through tap 6 and tap 1.
    sendBlock(pack4(0, 0, 0, 0), packW(0, 0, 0, 0, 0, 60), "R1 reset history tap6");
    sendBlock(pack4(-10, 0, 0, 0), packW(-20, 0, 0, 0, 0, 0), "R1 reset history tap1");
    idle(3);

    // R2: lane order, weights zero.
    sendBlock(pack4(-3, 4, -1, 0), packW(0, 0, 0, 0, 0, 0), "R2 lane order");
    sendBlock(pack4(5, -5, 5, -512), packW(0, 0, 0, 0, 0, 0), "R2 lane order extremes");

    // R9: exact zero sums.
    sendBlock(pack4(0, 0, 0, 0), packW(0, 0, 0, 0, 0, 0), "R9 zero sum");
    sendBlock(pack4(-5, -5, -5, -5), packW(5, 0, 0, 0, 0, 0), "R9 zero with tap1");

    // R7: in-block chaining, strong tap 1 alternates decisions.
    sendBlock(pack4(0, 0, 0, 0), packW(-100, 0, 0, 0, 0, 0), "R7 chain alternate");
    sendBlock(pack4(10, -30, 10, -30), packW(20, -15, 7, 0, 0, 0), "R7 chain three taps");

    // R3: each tap alone, checks weight byte positions.
    for (int k = 1; k <= 6; k++) begin
      logic [47:0] w;
      w = '0;
      w[8*(k-1) +: 8] = 8'(-70 + 25*k);
      sendBlock(pack4(3, -40, 12, -2), w, $sformatf("R3 tap%0d alone", k));
    end

    // R8: only tap 6, across back-to-back blocks.
    for (int b = 0; b < 4; b++)
      sendBlock(pack4(b*7-10, 5-b, -b, b), packW(0, 0, 0, 0, 0, -90), "R8 tap6 two blocks back");
    sendBlock(pack4(1, 1, 1, 1), packW(0, 0, 0, 0, 80, 0), "R8 tap5");

    // R6: idle gap keeps history.
    idle(3);
    check(outValid == 1'b0, "R6 no outValid in gap", int'(outValid), 0);
    sendBlock(pack4(0, 0, 0, 0), packW(0, 0, 0, 40, -50, 60), "R6 history across gap");
    idle(5);
    sendBlock(pack4(0, 0, 0, 0), packW(90, 0, 0, 0, 0, 0), "R6 history across long gap");

    // R10: weights change every block, back to back.
    sendBlock(pack4(20, 20, 20, 20), packW(-50, 0, 0, 0, 0, 0), "R10 weight set A");
    sendBlock(pack4(20, 20, 20, 20), packW(50, 0, 0, 0, 0, 0), "R10 weight set B");

    // R4/R10: random samples and weights, random gaps.
    for (int n = 0; n < 400; n++) begin
      sendBlock(40'({$urandom, $urandom}), 48'({$urandom, $urandom}), "R4 R10 random");
      if (($urandom % 5) == 0) idle(1 + $urandom % 3);
    end
    // R4: small weights relative to samples, long back-to-back run.
    for (int n = 0; n < 200; n++)
      sendBlock(40'({$urandom, $urandom}), packW(int'($urandom % 41) - 20, int'($urandom % 41) - 20,
                int'($urandom % 41) - 20, int'($urandom % 41) - 20, int'($urandom % 41) - 20,
                int'($urandom % 41) - 20), "R4 serial match");

    idle(6);
    check(expQ.size() == 0, "R5 all blocks delivered", expQ.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule